// File: doc/BRIEF.md
# Return Address Stack with Pointer-and-Value Repair

This block holds the return addresses of the calls that are in flight so that a front end can predict where each return goes. A call pushes the address of the instruction that follows it (the caller supplies this value: the call's PC plus one instruction size). A return reads the current top and then pops it. Both the top entry and the top pointer are visible combinationally, so the caller can record them alongside a predicted branch before it changes the stack.

Predictions can be wrong, so the stack has a repair operation. The caller gives back a pointer and an address it saved earlier. The block makes that pointer the top and writes the address into that slot. A wrong-path push is undone with a plain pop. A wrong-path pop, even one whose slot a later push has since overwritten, is undone by restoring the saved pointer and value. Storage is circular, so overflow and underflow wrap instead of stalling. The block accepts one operation per clock and has no back-pressure. Each operation arrives as a plain one-cycle strobe. Its effect is visible on the outputs after the next rising edge.

Top module: `ras_stack`

## Requirements
- R1: While reset is asserted, and just after it is released, the top pointer reads 0 and every entry holds 0. Popping through the whole stack after reset exposes only zeros.
- R2: A push with address A moves the top pointer to (pointer + 1) modulo DEPTH. It makes A the top value from the next cycle on.
- R3: A pop moves the top pointer to (pointer - 1) modulo DEPTH. It exposes the entry that was below the old top, with that entry's contents unchanged.
- R4: A restore with pointer P and value V makes P the top pointer and writes V into entry P. Both are visible after the next edge, and no other entry changes.
- R5: When restore is asserted in the same cycle as push or pop, only the restore takes effect.
- R6: A push made when DEPTH entries are already live wraps the pointer and overwrites the oldest entry. The wrapped pointer goes from DEPTH-1 to 0.
- R7: A pop at pointer 0 wraps the pointer to DEPTH-1 and exposes whatever that entry holds.
- R8: A cycle with no operation leaves the pointer and the top value unchanged. Push and pop are never asserted in the same cycle.
- R9: A push followed by a pop returns the pointer and the top value to what they were before the push.
- R10: Take a pop, then a push that overwrites the popped slot. A restore with the pointer and value saved before the pop then brings back the original top, and the entries below it are intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| push_addr_i | input | ADDR_W | Return address stored by a push |
| pop_i | input | 1 | Pop strobe |
| restore_i | input | 1 | Repair strobe; wins over push and pop |
| restore_ptr_i | input | PTR_W | Pointer that becomes the top on repair |
| restore_addr_i | input | ADDR_W | Value written into the restored slot |
| top_ptr_o | output | PTR_W | Current top pointer (combinational from state) |
| top_addr_o | output | ADDR_W | Entry at the top pointer (combinational from state) |

## Verification
The hardest case to reach is a repair after the popped slot has already been reused. Reaching it needs a pop, then a push that lands on the same index, then a restore with values captured before the pop. The bench builds that exact sequence, and afterwards pops further to confirm that the lower entries survived. Wrap-around in both directions is reached by popping straight out of reset and by pushing DEPTH+1 times in a row. A long stretch of mixed pushes, pops and restores driven from an LFSR, compared against a reference model, covers the remaining interleavings.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_FIX  = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
  import ras_pkg::*;
(
  input  logic    push,
  input  logic    pop,
  input  logic    restore,
  output ras_op_e op
);
  // Repair outranks both stack moves; push before pop only matters on misuse.
  always_comb begin
    if (restore)   op = RAS_FIX;
    else if (push) op = RAS_PUSH;
    else if (pop)  op = RAS_POP;
    else           op = RAS_IDLE;
  end
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_op_e          op,
  input  logic [PTR_W-1:0] fix_ptr,
  output logic [PTR_W-1:0] tos,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] up_ptr;
  logic [PTR_W-1:0] dn_ptr;
  logic [PTR_W-1:0] nxt_ptr;

  assign up_ptr = (tos == LAST) ? '0 : tos + 1'b1;
  assign dn_ptr = (tos == '0) ? LAST : tos - 1'b1;

  always_comb begin
    unique case (op)
      RAS_PUSH: nxt_ptr = up_ptr;
      RAS_POP:  nxt_ptr = dn_ptr;
      RAS_FIX:  nxt_ptr = fix_ptr;
      default:  nxt_ptr = tos;
    endcase
  end

  assign wr_en  = (op == RAS_PUSH) || (op == RAS_FIX);
  assign wr_idx = (op == RAS_FIX) ? fix_ptr : up_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos <= '0;
    else        tos <= nxt_ptr;
  end
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && (wr_idx == PTR_W'(i)))   q <= wr_data;
    end
    assign ent[i] = q;
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/ras_stack.sv
module ras_stack
  import ras_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  input  logic              restore_i,
  input  logic [PTR_W-1:0]  restore_ptr_i,
  input  logic [ADDR_W-1:0] restore_addr_i,
  output logic [PTR_W-1:0]  top_ptr_o,
  output logic [ADDR_W-1:0] top_addr_o
);
  ras_op_e           op;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_data;
  logic [PTR_W-1:0]  tos;

  ras_op_decode u_dec (
    .push    (push_i),
    .pop     (pop_i),
    .restore (restore_i),
    .op      (op)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .fix_ptr (restore_ptr_i),
    .tos     (tos),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx)
  );

  assign wr_data = (op == RAS_FIX) ? restore_addr_i : push_addr_i;

  ras_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (tos),
    .rd_data (top_addr_o)
  );

  assign top_ptr_o = tos;
endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic [ADDR_W-1:0] push_addr_i,
  input logic              pop_i,
  input logic              restore_i,
  input logic [PTR_W-1:0]  restore_ptr_i,
  input logic [ADDR_W-1:0] restore_addr_i,
  input logic [PTR_W-1:0]  top_ptr_o,
  input logic [ADDR_W-1:0] top_addr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] exp_up;
  logic [PTR_W-1:0] exp_dn;
  assign exp_up = (top_ptr_o == LAST) ? '0 : top_ptr_o + 1'b1;
  assign exp_dn = (top_ptr_o == '0) ? LAST : top_ptr_o - 1'b1;

  // R2
  push_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !restore_i) |=> (top_ptr_o == $past(exp_up)));

  // R2
  push_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !restore_i) |=> (top_addr_o == $past(push_addr_i)));

  // R3
  pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !restore_i && !push_i) |=> (top_ptr_o == $past(exp_dn)));

  // R4
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (top_ptr_o == $past(restore_ptr_i)) &&
                  (top_addr_o == $past(restore_addr_i)));

  // R8
  no_push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !restore_i) |=> ($stable(top_ptr_o) && $stable(top_addr_o)));
endmodule

bind ras_stack ras_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_i         (push_i),
  .push_addr_i    (push_addr_i),
  .pop_i          (pop_i),
  .restore_i      (restore_i),
  .restore_ptr_i  (restore_ptr_i),
  .restore_addr_i (restore_addr_i),
  .top_ptr_o      (top_ptr_o),
  .top_addr_o     (top_addr_o)
);

// File: tb/ras_stack_bench.sv
module ras_stack_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int PW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic          pop_i = 1'b0;
  logic          restore_i = 1'b0;
  logic [PW-1:0] restore_ptr_i = '0;
  logic [AW-1:0] restore_addr_i = '0;
  logic [PW-1:0] top_ptr_o;
  logic [AW-1:0] top_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ras_stack #(.DEPTH(DEPTH), .ADDR_W(AW)) u_ras_stack (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i),
    .restore_i(restore_i), .restore_ptr_i(restore_ptr_i),
    .restore_addr_i(restore_addr_i),
    .top_ptr_o(top_ptr_o), .top_addr_o(top_addr_o)
  );

  typedef struct {
    logic [PW-1:0] p;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  logic [AW-1:0] mdl [DEPTH];
  logic [PW-1:0] mptr;

  task automatic check(input string tag, input logic [PW-1:0] gp, input logic [AW-1:0] ga,
                       input logic [PW-1:0] ep, input logic [AW-1:0] ea);
    checks++;
    if (gp !== ep || ga !== ea) begin
      errors++;
      $display("FAIL %s: ptr=%0d addr=%h expected ptr=%0d addr=%h", tag, gp, ga, ep, ea);
    end
  endtask

  // Driver: applies one operation and queues the outcome expected after the next edge.
  task automatic drive(input logic pu, input logic po, input logic rs,
                       input logic [AW-1:0] a, input logic [PW-1:0] p, input string tag);
    @(negedge clk);
    push_i = pu; pop_i = po; restore_i = rs;
    push_addr_i = rs ? ~a : a;
    restore_addr_i = a;
    restore_ptr_i = p;
    if (rs) begin
      mptr = p; mdl[p] = a;
    end else if (pu) begin
      mptr = (mptr == PW'(DEPTH-1)) ? '0 : mptr + 1'b1;
      mdl[mptr] = a;
    end else if (po) begin
      mptr = (mptr == '0) ? PW'(DEPTH-1) : mptr - 1'b1;
    end
    sbq.push_back('{mptr, mdl[mptr], tag});
  endtask

  // Monitor: compares the outputs a quarter period after each rising edge.
  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(e.tag, top_ptr_o, top_addr_o, e.p, e.a);
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: ptr=%0d addr=%h expected completion", top_ptr_o, top_addr_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    mptr = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 in reset", top_ptr_o, top_addr_o, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R1 after release", top_ptr_o, top_addr_o, '0, '0);

    // R7 underflow wrap, then R1 zeros all the way round
    drive(0, 1, 0, '0, '0, "R7 pop at empty");
    for (int i = 0; i < DEPTH - 1; i++) drive(0, 1, 0, '0, '0, "R1 zero walk");
    drive(0, 0, 1, 32'h0, 3'd0, "R4 restore to base");

    // R2 / R3 basic
    drive(1, 0, 0, 32'h1000_0004, '0, "R2 push 1");
    drive(1, 0, 0, 32'h2000_0008, '0, "R2 push 2");
    drive(1, 0, 0, 32'h3000_000c, '0, "R2 push 3");
    drive(0, 1, 0, '0, '0, "R3 pop");
    drive(0, 0, 0, '0, '0, "R8 idle hold");
    drive(0, 0, 0, '0, '0, "R8 idle hold");

    // R9 speculative push undone by pop
    drive(1, 0, 0, 32'hdead_0010, '0, "R9 spec push");
    drive(0, 1, 0, '0, '0, "R9 undo pop");

    // R4 and R5
    drive(0, 0, 1, 32'h5555_aaaa, 3'd5, "R4 restore");
    drive(1, 0, 1, 32'h6666_0000, 3'd1, "R5 restore beats push");
    drive(0, 1, 1, 32'h7777_0000, 3'd6, "R5 restore beats pop");

    // R10 repair after slot reuse
    drive(0, 0, 1, 32'h0000_00a0, 3'd1, "R10 setup");
    drive(1, 0, 0, 32'h0000_00b0, '0, "R10 push B");
    drive(0, 1, 0, '0, '0, "R10 wrong-path pop");
    drive(1, 0, 0, 32'h0000_00c0, '0, "R10 overwrite slot");
    drive(0, 0, 1, 32'h0000_00b0, 3'd2, "R10 repair");
    drive(0, 1, 0, '0, '0, "R10 lower entry intact");

    // R6 overflow wrap
    for (int i = 0; i <= DEPTH; i++) drive(1, 0, 0, 32'hf000_0000 + AW'(i), '0, "R6 wrap push");
    for (int i = 0; i < DEPTH + 1; i++) drive(0, 1, 0, '0, '0, "R6 pop after wrap");

    // mixed traffic
    lfsr = 16'hace1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: drive(1, 0, 0, {lfsr, lfsr}, '0, "R2 mix push");
        2'd1: drive(0, 1, 0, '0, '0, "R3 mix pop");
        2'd2: drive(0, 0, lfsr[5] & lfsr[6], {16'h0, lfsr}, lfsr[4:2], "R4 mix restore");
        default: drive(0, 0, 0, '0, '0, "R8 mix idle");
      endcase
    end

    drive(0, 0, 0, '0, '0, "R8 final idle");
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; restore_i = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule